// File: doc/BRIEF.md
# Security Interrupt Status Aggregator

This block gathers interrupt level signals from a set of peripheral protection controllers, memory protection checkers and expansion master security controllers, and packs them into status words at fixed bit positions for a register file to read. It also holds the enable words for the protection controllers and the master controllers. It hands each protection controller its own enable line and a clear pulse, hands each master controller a clear pulse and a non-secure select line, and forms one combined master-controller interrupt.

The register file decodes bus accesses itself and presents each write to this block as a one-cycle strobe together with the 32-bit write data. The status, enable and non-secure words come out as plain registered outputs, so the register file can place them on its read path directly. Protection-controller sources are numbered on `ppc_lvl` as: index 0 and 1 for the two internal peripheral controllers, then `N_APB_EXP` peripheral expansion controllers, then `N_AHB_EXP` system-bus expansion controllers.

Top module: `secirq_agg`

## Requirements
- R1: While `rst` is high at a clock edge, every status, enable and non-secure word, every clear pulse output and `msc_irq` are zero after that edge.
- R2: Protection-controller source 0 reports at status bit 0, source 1 at bit 1, peripheral expansion source i (index 2+i) at bit 4+i and system-bus expansion source i (index 2+N_APB_EXP+i) at bit 20+i; all other bits read zero. A status bit takes the level of its input at the first clock edge at which that input differs from its value at the previous edge.
- R3: A write with `wr_ppc_clr` clears each protection-controller status bit whose position is set in `reg_wdata & 0x00F000F3`, with the level unchanged; if the source's input changes at the same edge, the input level is stored instead.
- R4: A `wr_ppc_clr` write drives `ppc_clr_o[k]` high for exactly the one cycle after the write when `reg_wdata` has source k's status bit position set, and leaves it low otherwise.
- R5: A `wr_ppc_en` write stores `reg_wdata & 0x00F000F3` in `ppc_en_word`; `ppc_en_o[k]` equals the enable bit at source k's status bit position.
- R6: `mpc_stat_word` bit n holds the level of internal memory checker n and bit 16+n the level of expansion checker n, one clock edge after the input; all other bits are zero.
- R7: `msc_stat_word` bit 16+n holds the level of `msc_lvl[n]` one edge after the input; all other bits are zero.
- R8: A `wr_msc_en` write stores all 32 bits of `reg_wdata` in `msc_en_word`.
- R9: `msc_irq` is high exactly when `msc_stat_word & msc_en_word` has any bit set, updating at the same edge as those words.
- R10: A `wr_msc_clr` write drives `msc_clr_o[n]` from `reg_wdata` bit 16+n for the one cycle after the write; otherwise `msc_clr_o` is zero.
- R11: A `wr_msc_ns` write stores all 32 bits of `reg_wdata` in `msc_ns_word`, and `msc_ns_o[n]` follows bit 16+n of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ppc_lvl | input | 2+N_APB_EXP+N_AHB_EXP | Protection-controller interrupt levels |
| mpc_lvl | input | N_MPC | Internal memory checker interrupt levels |
| mpc_exp_lvl | input | N_MPC_EXP | Expansion memory checker interrupt levels |
| msc_lvl | input | N_MSC_EXP | Expansion master-controller interrupt levels |
| reg_wdata | input | 32 | Write data for all write strobes |
| wr_ppc_en | input | 1 | Write strobe, protection-controller enable word |
| wr_ppc_clr | input | 1 | Write strobe, protection-controller clear |
| wr_msc_en | input | 1 | Write strobe, master-controller enable word |
| wr_msc_clr | input | 1 | Write strobe, master-controller clear |
| wr_msc_ns | input | 1 | Write strobe, master-controller non-secure word |
| ppc_stat_word | output | 32 | Packed protection-controller status |
| ppc_en_word | output | 32 | Protection-controller enable word |
| mpc_stat_word | output | 32 | Packed memory checker status |
| msc_stat_word | output | 32 | Packed master-controller status |
| msc_en_word | output | 32 | Master-controller enable word |
| msc_ns_word | output | 32 | Master-controller non-secure word |
| ppc_en_o | output | 2+N_APB_EXP+N_AHB_EXP | Per-source enable to protection controllers |
| ppc_clr_o | output | 2+N_APB_EXP+N_AHB_EXP | Per-source clear pulse to protection controllers |
| msc_clr_o | output | N_MSC_EXP | Per-source clear pulse to master controllers |
| msc_ns_o | output | N_MSC_EXP | Per-source non-secure select to master controllers |
| msc_irq | output | 1 | Combined master-controller interrupt |

## Verification
The assertions watch, on every cycle, that the combined interrupt agrees with the status and enable words, that each clear pulse only follows a clear strobe, that a clear with a steady level leaves the status bit low, that the memory checker bits trail their inputs by one edge and that a non-secure write lands on the select lines. Only the bench scenarios show the scattered bit placement of each protection-controller source, the masking of the enable word, the priority of an input change over a same-cycle clear, and which individual sources a given clear value reaches.

// File: rtl/secirq_pkg.sv
package secirq_pkg;

  localparam int WORD_W = 32;
  localparam int EXP_BASE = 16;

  // Status bit position of protection-controller source k.
  function automatic int ppc_pos(int k, int na);
    if (k < 2)
      return k;
    else if (k < 2 + na)
      return 4 + (k - 2);
    else
      return 20 + (k - 2 - na);
  endfunction

  // Mask of every protection-controller status position.
  function automatic logic [WORD_W-1:0] ppc_mask(int na, int nb);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < 2 + na + nb; k++) m[ppc_pos(k, na)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/secirq_ppc_bank.sv
module secirq_ppc_bank
  import secirq_pkg::*;
#(
  parameter int NA = 4,
  parameter int NB = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2+NA+NB-1:0]    lvl,
  input  logic [WORD_W-1:0]     wdata,
  input  logic                  wr_en,
  input  logic                  wr_clr,
  output logic [WORD_W-1:0]     stat_word,
  output logic [WORD_W-1:0]     en_word,
  output logic [2+NA+NB-1:0]    en_o,
  output logic [2+NA+NB-1:0]    clr_o
);

  localparam int NPPC = 2 + NA + NB;
  localparam logic [WORD_W-1:0] MASK = ppc_mask(NA, NB);

  logic [WORD_W-1:0] en_q;
  logic [NPPC-1:0]   stat_bits;

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wdata & MASK;
  end

  assign en_word = en_q;

  generate
    for (genvar k = 0; k < NPPC; k++) begin : g_src
      localparam int P = ppc_pos(k, NA);
      logic prev_r;
      logic stat_r;
      logic clr_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_r <= 1'b0;
          stat_r <= 1'b0;
          clr_r  <= 1'b0;
        end else begin
          prev_r <= lvl[k];
          clr_r  <= wr_clr & wdata[P];
          if (lvl[k] != prev_r)
            stat_r <= lvl[k];
          else if (wr_clr && wdata[P])
            stat_r <= 1'b0;
        end
      end

      assign stat_bits[k] = stat_r;
      assign clr_o[k]     = clr_r;
      assign en_o[k]      = en_q[P];

      // R4: a clear pulse only follows a clear strobe with this source's bit
      a_r4_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        clr_o[k] |-> $past(wr_clr && wdata[P]));

      // R3: a clear with an unchanged level leaves the status low
      a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && wdata[P] && (lvl[k] == prev_r)) |=> !stat_r);
    end
  endgenerate

  always_comb begin
    stat_word = '0;
    for (int k = 0; k < NPPC; k++) stat_word[ppc_pos(k, NA)] = stat_bits[k];
  end

endmodule

// File: rtl/secirq_mirror.sv
module secirq_mirror
  import secirq_pkg::*;
#(
  parameter int NI = 1,
  parameter int NE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NI-1:0]     lin,
  input  logic [NE-1:0]     lexp,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_nx;
  logic [WORD_W-1:0] word_q;

  always_comb begin
    word_nx = '0;
    word_nx[0 +: NI]        = lin;
    word_nx[EXP_BASE +: NE] = lexp;
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_nx;
  end

  assign word = word_q;

  // R6: packed bits trail the inputs by one edge
  a_r6_mirror_lag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (word[0 +: NI] == $past(lin)) && (word[EXP_BASE +: NE] == $past(lexp)));

endmodule

// File: rtl/secirq_msc.sv
module secirq_msc
  import secirq_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      lvl,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              wr_clr,
  input  logic              wr_ns,
  output logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] en_word,
  output logic [WORD_W-1:0] ns_word,
  output logic [N-1:0]      clr_o,
  output logic [N-1:0]      ns_o,
  output logic              irq
);

  logic [WORD_W-1:0] stat_q, stat_nx;
  logic [WORD_W-1:0] en_q, en_nx;
  logic [WORD_W-1:0] ns_q;
  logic [N-1:0]      clr_q;
  logic              irq_q;

  always_comb begin
    stat_nx = '0;
    stat_nx[EXP_BASE +: N] = lvl;
    en_nx = wr_en ? wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      ns_q   <= '0;
      clr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      en_q   <= en_nx;
      irq_q  <= |(stat_nx & en_nx);
      clr_q  <= wr_clr ? wdata[EXP_BASE +: N] : '0;
      if (wr_ns) ns_q <= wdata;
    end
  end

  assign stat_word = stat_q;
  assign en_word   = en_q;
  assign ns_word   = ns_q;
  assign clr_o     = clr_q;
  assign ns_o      = ns_q[EXP_BASE +: N];
  assign irq       = irq_q;

  // R9: combined interrupt agrees with the stored words
  a_r9_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq == |(stat_word & en_word));

  // R10: clear pulses only after a clear strobe
  a_r10_clr_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> $past(wr_clr));

  // R11: non-secure select lines take the written bits
  a_r11_ns_lands: assert property (@(posedge clk) disable iff (rst)
    wr_ns |=> ns_o == $past(wdata[EXP_BASE +: N]));

endmodule

// File: rtl/secirq_agg.sv
module secirq_agg
  import secirq_pkg::*;
#(
  parameter int N_APB_EXP = 4,
  parameter int N_AHB_EXP = 4,
  parameter int N_MPC     = 1,
  parameter int N_MPC_EXP = 4,
  parameter int N_MSC_EXP = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [2+N_APB_EXP+N_AHB_EXP-1:0]   ppc_lvl,
  input  logic [N_MPC-1:0]                   mpc_lvl,
  input  logic [N_MPC_EXP-1:0]               mpc_exp_lvl,
  input  logic [N_MSC_EXP-1:0]               msc_lvl,
  input  logic [31:0]                        reg_wdata,
  input  logic                               wr_ppc_en,
  input  logic                               wr_ppc_clr,
  input  logic                               wr_msc_en,
  input  logic                               wr_msc_clr,
  input  logic                               wr_msc_ns,
  output logic [31:0]                        ppc_stat_word,
  output logic [31:0]                        ppc_en_word,
  output logic [31:0]                        mpc_stat_word,
  output logic [31:0]                        msc_stat_word,
  output logic [31:0]                        msc_en_word,
  output logic [31:0]                        msc_ns_word,
  output logic [2+N_APB_EXP+N_AHB_EXP-1:0]   ppc_en_o,
  output logic [2+N_APB_EXP+N_AHB_EXP-1:0]   ppc_clr_o,
  output logic [N_MSC_EXP-1:0]               msc_clr_o,
  output logic [N_MSC_EXP-1:0]               msc_ns_o,
  output logic                               msc_irq
);

  secirq_ppc_bank #(.NA(N_APB_EXP), .NB(N_AHB_EXP)) u_ppc (
    .clk(clk), .rst(rst), .lvl(ppc_lvl), .wdata(reg_wdata),
    .wr_en(wr_ppc_en), .wr_clr(wr_ppc_clr),
    .stat_word(ppc_stat_word), .en_word(ppc_en_word),
    .en_o(ppc_en_o), .clr_o(ppc_clr_o)
  );

  secirq_mirror #(.NI(N_MPC), .NE(N_MPC_EXP)) u_mpc (
    .clk(clk), .rst(rst), .lin(mpc_lvl), .lexp(mpc_exp_lvl),
    .word(mpc_stat_word)
  );

  secirq_msc #(.N(N_MSC_EXP)) u_msc (
    .clk(clk), .rst(rst), .lvl(msc_lvl), .wdata(reg_wdata),
    .wr_en(wr_msc_en), .wr_clr(wr_msc_clr), .wr_ns(wr_msc_ns),
    .stat_word(msc_stat_word), .en_word(msc_en_word), .ns_word(msc_ns_word),
    .clr_o(msc_clr_o), .ns_o(msc_ns_o), .irq(msc_irq)
  );

  // R1: outputs are quiet right after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (ppc_stat_word == '0) && (ppc_clr_o == '0) && !msc_irq);

endmodule

// File: tb/secirq_agg_test.sv
module secirq_agg_test;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int NB = 4;
  localparam int NP = 2 + NA + NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] ppc_lvl = '0;
  logic [0:0]    mpc_lvl = '0;
  logic [3:0]    mpc_exp_lvl = '0;
  logic [3:0]    msc_lvl = '0;
  logic [31:0]   reg_wdata = '0;
  logic wr_ppc_en = 0, wr_ppc_clr = 0, wr_msc_en = 0, wr_msc_clr = 0, wr_msc_ns = 0;
  logic [31:0] ppc_stat_word, ppc_en_word, mpc_stat_word, msc_stat_word, msc_en_word, msc_ns_word;
  logic [NP-1:0] ppc_en_o, ppc_clr_o;
  logic [3:0]    msc_clr_o, msc_ns_o;
  logic          msc_irq;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secirq_agg uut (
    .clk(clk), .rst(rst), .ppc_lvl(ppc_lvl), .mpc_lvl(mpc_lvl),
    .mpc_exp_lvl(mpc_exp_lvl), .msc_lvl(msc_lvl), .reg_wdata(reg_wdata),
    .wr_ppc_en(wr_ppc_en), .wr_ppc_clr(wr_ppc_clr), .wr_msc_en(wr_msc_en),
    .wr_msc_clr(wr_msc_clr), .wr_msc_ns(wr_msc_ns),
    .ppc_stat_word(ppc_stat_word), .ppc_en_word(ppc_en_word),
    .mpc_stat_word(mpc_stat_word), .msc_stat_word(msc_stat_word),
    .msc_en_word(msc_en_word), .msc_ns_word(msc_ns_word),
    .ppc_en_o(ppc_en_o), .ppc_clr_o(ppc_clr_o), .msc_clr_o(msc_clr_o),
    .msc_ns_o(msc_ns_o), .msc_irq(msc_irq)
  );

  function automatic int bpos(int k);
    if (k < 2) return k;
    if (k < 2 + NA) return 4 + k - 2;
    return 20 + k - 2 - NA;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ppc stat", ppc_stat_word, 0);
    chk("R1 ppc en", ppc_en_word, 0);
    chk("R1 mpc stat", mpc_stat_word, 0);
    chk("R1 msc words", msc_stat_word | msc_en_word | msc_ns_word, 0);
    chk("R1 pulses", {ppc_clr_o, msc_clr_o, msc_irq}, 0);
  endtask

  task automatic t_positions();
    for (int k = 0; k < NP; k++) begin
      ppc_lvl = NP'(1) << k;
      step();
      chk("R2 placement", ppc_stat_word, 32'd1 << bpos(k));
      ppc_lvl = '0;
      step();
      chk("R2 level low", ppc_stat_word, 0);
    end
  endtask

  task automatic t_clear();
    ppc_lvl = '1;
    step();
    chk("R2 all set", ppc_stat_word, 32'h00F000F3);
    reg_wdata = 32'h0000_0010; wr_ppc_clr = 1;
    step();
    wr_ppc_clr = 0;
    chk("R3 partial clear", ppc_stat_word, 32'h00F000E3);
    chk("R4 pulse one source", 32'(ppc_clr_o), 32'h0000_0004);
    step();
    chk("R4 pulse ends", 32'(ppc_clr_o), 0);
    reg_wdata = 32'hFFFF_FFFF; wr_ppc_clr = 1;
    step();
    wr_ppc_clr = 0;
    chk("R3 full clear", ppc_stat_word, 0);
    chk("R4 pulse all", 32'(ppc_clr_o), 32'(NP'('1)));
    ppc_lvl = '0;
    step();
    // input rising in the same cycle as a clear: level wins
    ppc_lvl[0] = 1'b1; reg_wdata = 32'h1; wr_ppc_clr = 1;
    step();
    wr_ppc_clr = 0;
    chk("R3 change beats clear", ppc_stat_word, 32'h1);
    ppc_lvl = '0;
    step();
  endtask

  task automatic t_enable();
    reg_wdata = 32'hFFFF_FFFF; wr_ppc_en = 1;
    step();
    wr_ppc_en = 0;
    chk("R5 masked word", ppc_en_word, 32'h00F000F3);
    chk("R5 all lines", 32'(ppc_en_o), 32'(NP'('1)));
    reg_wdata = 32'h0010_0002; wr_ppc_en = 1;
    step();
    wr_ppc_en = 0;
    chk("R5 select lines", 32'(ppc_en_o), 32'h0000_0042);
  endtask

  task automatic t_mpc();
    mpc_lvl = 1'b1; mpc_exp_lvl = 4'b1010;
    step();
    chk("R6 checker bits", mpc_stat_word, 32'h000A_0001);
    mpc_lvl = 1'b0; mpc_exp_lvl = 4'b0001;
    step();
    chk("R6 checker follow", mpc_stat_word, 32'h0001_0000);
  endtask

  task automatic t_msc();
    msc_lvl = 4'b0100;
    step();
    chk("R7 status bit", msc_stat_word, 32'h0004_0000);
    chk("R9 irq off, no enable", 32'(msc_irq), 0);
    reg_wdata = 32'hDEAD_BEEF; wr_msc_en = 1;
    step();
    wr_msc_en = 0;
    chk("R8 full enable word", msc_en_word, 32'hDEAD_BEEF);
    chk("R9 irq on", 32'(msc_irq), 1);
    reg_wdata = 32'hFFFB_0000; wr_msc_en = 1;
    step();
    wr_msc_en = 0;
    chk("R9 irq off, other bits", 32'(msc_irq), 0);
    msc_lvl = 4'b1100;
    step();
    chk("R9 irq on status", 32'(msc_irq), 1);
    msc_lvl = 4'b0000;
    step();
    chk("R9 irq drop", 32'(msc_irq), 0);
  endtask

  task automatic t_msc_clr_ns();
    reg_wdata = 32'h0005_FFFF; wr_msc_clr = 1;
    step();
    wr_msc_clr = 0;
    chk("R10 clear pulse", 32'(msc_clr_o), 32'h5);
    step();
    chk("R10 pulse ends", 32'(msc_clr_o), 0);
    reg_wdata = 32'h000A_1234; wr_msc_ns = 1;
    step();
    wr_msc_ns = 0;
    chk("R11 ns word", msc_ns_word, 32'h000A_1234);
    chk("R11 ns lines", 32'(msc_ns_o), 32'hA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_positions();
    t_clear();
    t_enable();
    t_mpc();
    t_msc();
    t_msc_clr_ns();
    summary();
  end

endmodule